// File: doc/BRIEF.md
# Dual-Direction Universal Bus Register

This block sits between two 18-bit ports, A and B, and moves data in each direction through its own storage element. Each direction has four controls: an active-low output enable, a latch enable, an external data clock and an active-low clock enable. With the latch enable high, the direction is transparent and its destination output follows the source input. With the latch enable low, the direction either captures the source on a rising edge of its data clock or holds its stored value.

The ports are split into separate input, output and drive-enable vectors, so no tri-state logic is needed. A surrounding pad ring or a bus fabric resolves the drive enables.

The two external data clocks are treated as asynchronous. Each is synchronized into the fast system clock domain before its rising edges are detected. A registered contention flag reports when both directions drive at the same time.

Top module: `univ_bus_reg`

## Requirements
- R1: While a direction's latch enable is 1, its destination output takes the source input value at every system clock edge. The output therefore follows the input with one cycle of delay.
- R2: While the latch enable is 0 and the clock enable is 0, a 0-to-1 change of the data clock stores the source value. The source value is sampled at the third system clock edge after the change, and the stored value appears on the destination output.
- R3: While the latch enable is 0 and the clock enable is 1, rising data clock edges leave the stored value unchanged.
- R4: While the latch enable is 0 and the data clock stays constant or falls, the stored value is held whatever the source input does.
- R5: When the latch enable falls, the last transparent value stays on the destination output.
- R6: A drive-enable vector is all ones one cycle after its output enable is 0, and all zeros one cycle after its output enable is 1.
- R7: The B-to-A direction (B source, A destination) uses only its own four controls. The A-to-B controls have no effect on it, and the reverse holds as well.
- R8: Synchronous reset clears both stored values to zero. Reset leaves the drive enables under output-enable control.
- R9: The contention flag is 1 one cycle after both output enables are 0 together, and 0 otherwise.
- R10: A data clock that is held at 1 across reset release causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Port A input data (source for A-to-B) |
| a_out | output | 18 | Port A output data (B-to-A destination) |
| a_drv | output | 18 | Port A drive enable, 1 = driven |
| b_in | input | 18 | Port B input data (source for B-to-A) |
| b_out | output | 18 | Port B output data (A-to-B destination) |
| b_drv | output | 18 | Port B drive enable, 1 = driven |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_xclk | input | 1 | A-to-B data clock (asynchronous) |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_xclk | input | 1 | B-to-A data clock (asynchronous) |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| contention | output | 1 | Both directions driving |

## Verification
The assertions assume the following about the inputs:
- Latch enables, clock enables, output enables and data inputs are synchronous to the system clock.
- The source data stays steady from a data clock change until the capture three cycles later.
- The clock enable does not change within that window.

Only the data clocks are asynchronous. The stimulus changes every input at the falling system clock edge, and it holds each stimulus step for four cycles. This gives every synchronized edge time to land before the outputs are sampled.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
  localparam int unsigned DATA_W      = 18;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned NUM_DIRS    = 2;

  typedef struct packed {
    logic oe_n;
    logic le;
    logic xclk;
    logic ce_n;
  } dir_ctl_t;
endpackage

// File: rtl/ubr_edge_sync.sv
module ubr_edge_sync #(
  parameter int unsigned STAGES = ubr_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  localparam int unsigned MSB = STAGES - 1;

  logic [MSB:0] sh_q;
  logic         prev_q;

  // Under reset every stage loads the raw level, so a level held
  // across reset release produces no edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= {STAGES{async_in}};
      prev_q <= async_in;
    end else begin
      sh_q   <= {sh_q[MSB-1:0], async_in};
      prev_q <= sh_q[MSB];
    end
  end

  assign rise_o = sh_q[MSB] & ~prev_q;

  // R10
  no_reset_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !rise_o);
endmodule

// File: rtl/ubr_dir_path.sv
module ubr_dir_path #(
  parameter int unsigned W = ubr_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic         le,
  input  logic         ce_n,
  input  logic         oe_n,
  input  logic         edge_rise,
  output logic [W-1:0] q,
  output logic [W-1:0] drv
);
  logic [W-1:0] store_q;
  logic         load;

  assign load = le | (edge_rise & ~ce_n);

  always_ff @(posedge clk) begin
    if (rst)       store_q <= '0;
    else if (load) store_q <= src;
  end

  // The drive enable follows its pin even while reset is asserted.
  always_ff @(posedge clk) begin
    drv <= {W{~oe_n}};
  end

  assign q = store_q;

  // R1
  transparent_follow_chk: assert property (@(posedge clk) disable iff (rst)
    le |=> q == $past(src));
  // R2
  edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!le && !ce_n && edge_rise) |=> q == $past(src));
  // R3
  ce_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!le && ce_n) |=> $stable(q));
  // R4
  hold_no_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!le && !edge_rise) |=> $stable(q));
  // R6
  drive_on_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n |=> &drv);
  // R6
  drive_off_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> drv == '0);
endmodule

// File: rtl/univ_bus_reg.sv
module univ_bus_reg #(
  parameter int unsigned W      = ubr_pkg::DATA_W,
  parameter int unsigned STAGES = ubr_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_drv,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_drv,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_xclk,
  input  logic         ab_ce_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_xclk,
  input  logic         ba_ce_n,
  output logic         contention
);
  import ubr_pkg::*;

  localparam int unsigned ND = NUM_DIRS;

  // Index 0: A source to B destination. Index 1: B source to A destination.
  dir_ctl_t     ctl  [ND];
  logic [W-1:0] src  [ND];
  logic [W-1:0] q    [ND];
  logic [W-1:0] drv  [ND];
  logic         rise [ND];

  assign ctl[0] = '{oe_n: ab_oe_n, le: ab_le, xclk: ab_xclk, ce_n: ab_ce_n};
  assign ctl[1] = '{oe_n: ba_oe_n, le: ba_le, xclk: ba_xclk, ce_n: ba_ce_n};
  assign src[0] = a_in;
  assign src[1] = b_in;

  for (genvar d = 0; d < ND; d++) begin : g_dir
    ubr_edge_sync #(.STAGES(STAGES)) i_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (ctl[d].xclk),
      .rise_o   (rise[d])
    );

    ubr_dir_path #(.W(W)) i_path (
      .clk       (clk),
      .rst       (rst),
      .src       (src[d]),
      .le        (ctl[d].le),
      .ce_n      (ctl[d].ce_n),
      .oe_n      (ctl[d].oe_n),
      .edge_rise (rise[d]),
      .q         (q[d]),
      .drv       (drv[d])
    );
  end

  assign b_out = q[0];
  assign b_drv = drv[0];
  assign a_out = q[1];
  assign a_drv = drv[1];

  always_ff @(posedge clk) begin
    contention <= ~ab_oe_n & ~ba_oe_n;
  end

  // R9
  contention_chk: assert property (@(posedge clk) disable iff (rst)
    contention == ((&a_drv) && (&b_drv)));
endmodule

// File: tb/test_univ_bus_reg.sv
module test_univ_bus_reg;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_drv, b_out, b_drv;
  logic ab_oe_n = 1'b0, ab_le = 1'b0, ab_xclk = 1'b0, ab_ce_n = 1'b0;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_xclk = 1'b0, ba_ce_n = 1'b1;
  logic contention;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  univ_bus_reg i_univ_bus_reg (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_xclk(ab_xclk), .ab_ce_n(ab_ce_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_xclk(ba_xclk), .ba_ce_n(ba_ce_n),
    .contention(contention)
  );

  typedef struct packed {
    logic         le;
    logic         ce_n;
    logic         xclk;
    logic [17:0]  din;
    logic [17:0]  exp;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 18'h12345, 18'h12345, 4'd1},  // R1 transparent
    '{1'b1, 1'b0, 1'b0, 18'h2AAAA, 18'h2AAAA, 4'd1},  // R1 transparent
    '{1'b0, 1'b0, 1'b0, 18'h15555, 18'h2AAAA, 4'd5},  // R5 latch closes
    '{1'b0, 1'b0, 1'b1, 18'h0F0F0, 18'h0F0F0, 4'd2},  // R2 rising edge captures
    '{1'b0, 1'b0, 1'b1, 18'h3FFFF, 18'h0F0F0, 4'd4},  // R4 clock steady high
    '{1'b0, 1'b0, 1'b0, 18'h00001, 18'h0F0F0, 4'd4},  // R4 falling edge
    '{1'b0, 1'b1, 1'b1, 18'h11111, 18'h0F0F0, 4'd3},  // R3 blocked rising edge
    '{1'b0, 1'b1, 1'b0, 18'h22222, 18'h0F0F0, 4'd3},  // R3 blocked
    '{1'b0, 1'b0, 1'b1, 18'h33333, 18'h33333, 4'd2},  // R2 capture again
    '{1'b1, 1'b0, 1'b1, 18'h3C3C3, 18'h3C3C3, 4'd1},  // R1 transparent, clock high
    '{1'b0, 1'b0, 1'b1, 18'h00000, 18'h3C3C3, 4'd5}   // R5 fall with clock high
  };

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    settle(3);
    rst = 1'b0;
    settle(1);
    // R8: outputs clear after reset, drive follows output enables.
    check("R8", b_out, '0);
    check("R8", a_out, '0);
    check("R6", b_drv, '1);
    check("R6", a_drv, '0);
    check("R9", {17'd0, contention}, '0);

    // R7: B-to-A source changes while held; its output must stay at 0.
    for (int i = 0; i < NV; i++) begin
      ab_le   = VECS[i].le;
      ab_ce_n = VECS[i].ce_n;
      ab_xclk = VECS[i].xclk;
      a_in    = VECS[i].din;
      b_in    = VECS[i].din ^ 18'h3FFFF;
      settle(4);
      check($sformatf("R%0d", VECS[i].req), b_out, VECS[i].exp);
      check("R7", a_out, '0);
    end

    // R7: B-to-A is transparent while A-to-B stays held.
    ba_le = 1'b1;
    b_in  = 18'h0ABCD;
    a_in  = 18'h01010;
    settle(2);
    check("R7", a_out, 18'h0ABCD);
    check("R7", b_out, 18'h3C3C3);

    // R6 and R9: output enables and contention.
    ba_oe_n = 1'b0;
    settle(1);
    check("R6", a_drv, '1);
    check("R9", {17'd0, contention}, 18'd1);
    ab_oe_n = 1'b1;
    settle(1);
    check("R6", b_drv, '0);
    check("R9", {17'd0, contention}, '0);
    ab_oe_n = 1'b0;

    // R8: reset in the middle of operation.
    ba_le = 1'b0;
    rst   = 1'b1;
    settle(2);
    check("R8", b_out, '0);
    check("R8", a_out, '0);
    check("R8", b_drv, '1);

    // R10: data clock held high across reset release gives no capture.
    ab_le   = 1'b0;
    ab_ce_n = 1'b0;
    ab_xclk = 1'b1;
    settle(2);
    rst  = 1'b0;
    a_in = 18'h01234;
    settle(5);
    check("R10", b_out, '0);

    // R2: a later real rising edge does capture.
    ab_xclk = 1'b0;
    settle(4);
    ab_xclk = 1'b1;
    settle(4);
    check("R2", b_out, 18'h01234);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule